// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This engine moves a rectangle of 8-bit pixels inside one frame buffer. A start strobe samples three packed coordinate words (source corner, destination corner and rectangle size), a raster-operation word, a plane mask and a control-plane word. The engine then walks the rectangle pixel by pixel. For each pixel it reads the source byte, reads the destination byte, and writes back the destination byte after combining the two through a plane-masked raster operation. All traffic uses a single synchronous memory port with one cycle of read latency. The frame buffer is addressed linearly as row times buffer width plus column.

The walk direction is chosen from the two corners. Because of this, a copy whose source and destination overlap produces the same result as copying from an untouched snapshot of the source. The size is first clipped to the buffer dimensions. Any pixel that would touch an address beyond the end of the buffer is skipped. A busy flag covers the whole operation, and a one-cycle done pulse marks its end.

Top module: `rect_copy_engine`

## Requirements
- R1: Every coordinate word carries X in bits 31:16 and Y in bits 15:0; the size word carries width in bits 31:16 and height in bits 15:0; pixel (x, y) sits at linear address y*BUF_W + x. All inputs are sampled on the accepted start strobe.
- R2: If destination Y is greater than source Y, rows are visited from the bottom row of the rectangle upward; otherwise from the top row downward.
- R3: If destination X is greater than source X, each row is visited from its rightmost column leftward; otherwise from its leftmost column rightward.
- R4: Width is limited to BUF_W and height to BUF_H before the walk begins.
- R5: A pixel whose source or destination linear address is at or above BUF_W*BUF_H causes no memory access and no write; the walk proceeds to the next pixel in one cycle.
- R6: The raster-op code is bits 11:8 of the op word, with m the mask: code 0 gives dst&~m; code 3 gives (dst&~m)|(src&m); code 6 gives dst^(src&m); code 10 gives dst^m; code 15 gives dst|m.
- R7: Any other raster-op code writes back the destination byte unchanged.
- R8: Only bits 7:0 of the plane-mask word are used, and destination bits outside that mask are never altered.
- R9: A start strobe while the control-plane word is nonzero is ignored: busy stays low and nothing is written.
- R10: Each copied pixel uses three consecutive cycles on the port: source read, destination read, destination write. Writes are never back to back.
- R11: busy is high from the cycle after an accepted start until the final pixel's cycle. It falls on the next edge, at which done pulses high for exactly one cycle. The busy time is 3 cycles per written pixel plus 1 per skipped pixel, or 1 cycle for an empty rectangle. A start strobe while busy is ignored.
- R12: After reset, busy, done and the memory write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe |
| src_xy | input | 32 | Source corner, X high half, Y low half |
| dst_xy | input | 32 | Destination corner, X high half, Y low half |
| size_wh | input | 32 | Width high half, height low half |
| op_word | input | 32 | Raster-op code in bits 11:8 |
| plane_mask | input | 32 | Plane mask, low byte used |
| ctrl_plane | input | 32 | Nonzero blocks a start |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Frame buffer linear address |
| mem_we | output | 1 | Frame buffer write enable |
| mem_wdata | output | 8 | Frame buffer write byte |
| mem_rdata | input | 8 | Frame buffer read byte, one cycle after address |

## Verification
Some rules are checked by assertions on every cycle:
- Bits outside the plane mask survive each write.
- No write reaches an address beyond the buffer.
- Writes never come back to back.
- done is a single-cycle pulse while busy is low, and a start under a nonzero control plane leaves busy low.
- The walk counters stay inside the clipped rectangle.

Other behaviour can only be shown by the bench scenarios, which compare the exact order and content of writes against a reference walk:
- The traversal order in overlapping copies.
- The individual raster-op results.
- The clipping and skipping at the buffer edges.
- The busy length.
- A start ignored during a copy.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  localparam int COORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_WR
  } rc_state_e;

  localparam logic [3:0] ROP_CLEAR = 4'd0;
  localparam logic [3:0] ROP_COPY  = 4'd3;
  localparam logic [3:0] ROP_XOR   = 4'd6;
  localparam logic [3:0] ROP_INV   = 4'd10;
  localparam logic [3:0] ROP_SET   = 4'd15;

  function automatic logic [COORD_W-1:0] hi_half(input logic [31:0] w);
    return w[31:16];
  endfunction

  function automatic logic [COORD_W-1:0] lo_half(input logic [31:0] w);
    return w[15:0];
  endfunction
endpackage

// File: rtl/rcopy_rop.sv
module rcopy_rop
  import rcopy_pkg::*;
(
  input  logic [3:0] op,
  input  logic [7:0] mask,
  input  logic [7:0] src,
  input  logic [7:0] dst,
  output logic [7:0] res
);
  always_comb begin
    unique case (op)
      ROP_CLEAR: res = dst & ~mask;
      ROP_COPY:  res = (dst & ~mask) | (src & mask);
      ROP_XOR:   res = dst ^ (src & mask);
      ROP_INV:   res = dst ^ mask;
      ROP_SET:   res = dst | mask;
      default:   res = dst;
    endcase
  end
endmodule

// File: rtl/rcopy_walker.sv
module rcopy_walker #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] w_in,
  input  logic [CW-1:0] h_in,
  input  logic          rev_row_in,
  input  logic          rev_col_in,
  output logic [CW-1:0] row_off,
  output logic [CW-1:0] col_off,
  output logic          last,
  output logic          empty
);
  logic [CW-1:0] w_q, h_q, row_i, col_i;
  logic          rr_q, rc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      h_q   <= '0;
      row_i <= '0;
      col_i <= '0;
      rr_q  <= 1'b0;
      rc_q  <= 1'b0;
    end else if (load) begin
      w_q   <= w_in;
      h_q   <= h_in;
      row_i <= '0;
      col_i <= '0;
      rr_q  <= rev_row_in;
      rc_q  <= rev_col_in;
    end else if (step) begin
      if (col_i == w_q - CW'(1)) begin
        col_i <= '0;
        row_i <= row_i + CW'(1);
      end else begin
        col_i <= col_i + CW'(1);
      end
    end
  end

  assign empty   = (w_q == '0) || (h_q == '0);
  assign last    = (col_i == w_q - CW'(1)) && (row_i == h_q - CW'(1));
  assign row_off = rr_q ? (h_q - CW'(1) - row_i) : row_i;
  assign col_off = rc_q ? (w_q - CW'(1) - col_i) : col_i;

  // R4
  walk_range_chk: assert property (@(posedge clk) disable iff (rst)
    !empty |-> ((row_i < h_q) && (col_i < w_q)));
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
  import rcopy_pkg::*;
#(
  parameter int BUF_W = 16,
  parameter int BUF_H = 12,
  parameter int SIZE  = BUF_W * BUF_H,
  parameter int AW    = $clog2(SIZE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   src_xy,
  input  logic [31:0]   dst_xy,
  input  logic [31:0]   size_wh,
  input  logic [31:0]   op_word,
  input  logic [31:0]   plane_mask,
  input  logic [31:0]   ctrl_plane,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int CW = COORD_W;
  localparam int LW = 2 * CW + 2;

  rc_state_e     state;
  logic [CW-1:0] sx_q, sy_q, dx_q, dy_q;
  logic [3:0]    op_q;
  logic [7:0]    mask_q, src_q;
  logic [CW-1:0] clip_w, clip_h, row_off, col_off;
  logic          last, empty, skip, load, step, start_ok;
  logic [LW-1:0] src_lin, dst_lin;

  assign clip_w = (hi_half(size_wh) > CW'(BUF_W)) ? CW'(BUF_W) : hi_half(size_wh);
  assign clip_h = (lo_half(size_wh) > CW'(BUF_H)) ? CW'(BUF_H) : lo_half(size_wh);
  assign start_ok = start && (state == ST_IDLE) && (ctrl_plane == 32'h0);
  assign load = start_ok;

  rcopy_walker #(.CW(CW)) u_walker (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (step),
    .w_in       (clip_w),
    .h_in       (clip_h),
    .rev_row_in (lo_half(dst_xy) > lo_half(src_xy)),
    .rev_col_in (hi_half(dst_xy) > hi_half(src_xy)),
    .row_off    (row_off),
    .col_off    (col_off),
    .last       (last),
    .empty      (empty)
  );

  assign src_lin = (LW'(sy_q) + LW'(row_off)) * LW'(BUF_W) + LW'(sx_q) + LW'(col_off);
  assign dst_lin = (LW'(dy_q) + LW'(row_off)) * LW'(BUF_W) + LW'(dx_q) + LW'(col_off);
  assign skip    = (src_lin >= LW'(SIZE)) || (dst_lin >= LW'(SIZE));

  always_comb begin
    step = 1'b0;
    if (!empty && !last) begin
      if ((state == ST_SRC && skip) || state == ST_WR) step = 1'b1;
    end
  end

  rcopy_rop u_rop (
    .op   (op_q),
    .mask (mask_q),
    .src  (src_q),
    .dst  (mem_rdata),
    .res  (mem_wdata)
  );

  assign mem_we   = (state == ST_WR);
  assign mem_addr = (state == ST_SRC) ? src_lin[AW-1:0] : dst_lin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      sx_q   <= '0;
      sy_q   <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      op_q   <= '0;
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            sx_q   <= hi_half(src_xy);
            sy_q   <= lo_half(src_xy);
            dx_q   <= hi_half(dst_xy);
            dy_q   <= lo_half(dst_xy);
            op_q   <= op_word[11:8];
            mask_q <= plane_mask[7:0];
            busy   <= 1'b1;
            state  <= ST_SRC;
          end
        end
        ST_SRC: begin
          if (empty || (skip && last)) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else if (!skip) begin
            state <= ST_DST;
          end
        end
        ST_DST: begin
          src_q <= mem_rdata;
          state <= ST_WR;
        end
        ST_WR: begin
          if (last) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state <= ST_SRC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (dst_lin < LW'(SIZE)));
  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (((mem_wdata ^ mem_rdata) & ~mask_q) == 8'h00));
  // R10
  write_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  plane_block_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (ctrl_plane != 32'h0)) |=> !busy);
endmodule

// File: tb/test_rect_copy_engine.sv
module test_rect_copy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam int BH = 12;
  localparam int SZ = BW * BH;
  localparam int AW = $clog2(SZ);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   src_xy = '0, dst_xy = '0, size_wh = '0;
  logic [31:0]   op_word = '0, plane_mask = '0, ctrl_plane = '0;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;

  logic [7:0] mem   [0:(1<<AW)-1];
  logic [7:0] model [0:(1<<AW)-1];
  logic [15:0] exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_copy_engine #(.BUF_W(BW), .BUF_H(BH)) i_rect_copy_engine (
    .clk(clk), .rst(rst), .start(start), .src_xy(src_xy), .dst_xy(dst_xy),
    .size_wh(size_wh), .op_word(op_word), .plane_mask(plane_mask),
    .ctrl_plane(ctrl_plane), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each write compared with the next expected item
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R9/R11 unexpected write", int'({mem_addr, mem_wdata}), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({8'(mem_addr), mem_wdata} == e, "R1/R2/R3/R6 write addr+data",
              int'({8'(mem_addr), mem_wdata}), int'(e));
      end
    end
  end

  function automatic logic [7:0] ref_rop(input logic [3:0] op, input logic [7:0] m,
                                         input logic [7:0] s, input logic [7:0] d);
    case (op)
      4'd0:  return d & ~m;
      4'd3:  return (d & ~m) | (s & m);
      4'd6:  return d ^ (s & m);
      4'd10: return d ^ m;
      4'd15: return d | m;
      default: return d;
    endcase
  endfunction

  task automatic run_copy(input logic [31:0] s, input logic [31:0] d, input logic [31:0] z,
                          input logic [31:0] op, input logic [31:0] m, input logic [31:0] cp,
                          input bit poke, input string tag);
    int w, h, nwr, nskip, expc, cnt;
    bit rr, rc, runs;
    runs = (cp == 0);
    w = (z[31:16] > BW) ? BW : int'(z[31:16]);
    h = (z[15:0] > BH) ? BH : int'(z[15:0]);
    rr = d[15:0] > s[15:0];
    rc = d[31:16] > s[31:16];
    nwr = 0;
    nskip = 0;
    if (runs) begin
      for (int r = 0; r < h; r++) begin
        for (int c = 0; c < w; c++) begin
          int ro, co, sa, da;
          ro = rr ? h - 1 - r : r;
          co = rc ? w - 1 - c : c;
          sa = (int'(s[15:0]) + ro) * BW + int'(s[31:16]) + co;
          da = (int'(d[15:0]) + ro) * BW + int'(d[31:16]) + co;
          if (sa >= SZ || da >= SZ) begin
            nskip++;
          end else begin
            model[da] = ref_rop(op[11:8], m[7:0], model[sa], model[da]);
            exp_q.push_back({8'(da), model[da]});
            nwr++;
          end
        end
      end
    end
    expc = (w == 0 || h == 0) ? 1 : 3 * nwr + nskip;
    @(negedge clk);
    src_xy = s; dst_xy = d; size_wh = z; op_word = op; plane_mask = m; ctrl_plane = cp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!runs) begin
      for (int i = 0; i < 6; i++) begin
        check(!busy && !done, {tag, " R9 start ignored"}, int'({busy, done}), 0);
        @(negedge clk);
      end
      ctrl_plane = '0;
      return;
    end
    check(busy, {tag, " R11 busy rises"}, int'(busy), 1);
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1;
        src_xy = 32'h0000_0000;
        size_wh = 32'h0002_0002;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == expc, {tag, " R10/R11 busy cycles"}, cnt, expc);
    check(done, {tag, " R11 done pulse"}, int'(done), 1);
    check(exp_q.size() == 0, {tag, " R5 all writes seen"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !busy, {tag, " R11 done one cycle"}, int'({busy, done}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = 8'(i * 37 + 5);
      model[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12
    check(!busy && !done && !mem_we, "R12 reset state", int'({busy, done, mem_we}), 0);
    // R1 R2 R3 disjoint, both reversed
    run_copy(32'h0001_0001, 32'h0008_0002, 32'h0004_0003, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T2");
    // R2 R3 overlap down-right
    run_copy(32'h0002_0002, 32'h0003_0003, 32'h0005_0004, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T3");
    // R2 R3 overlap up-left
    run_copy(32'h0004_0005, 32'h0002_0003, 32'h0006_0003, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T4");
    // R3 reversed columns, forward rows
    run_copy(32'h0002_0006, 32'h0005_0004, 32'h0004_0002, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T5");
    // R4 R5 oversize clipped, destination runs off the end
    run_copy(32'h0000_0000, 32'h0002_0001, 32'h0100_0050, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T6");
    // R5 source runs off the end
    run_copy(32'h0003_000A, 32'h0003_0000, 32'h0004_0004, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T7");
    // R6 R8 each code with a partial mask, upper mask bits ignored
    run_copy(32'h0000_0000, 32'h0008_0006, 32'h0003_0002, 32'hFFFF_F0FF, 32'hFFFF_FF3C, 0, 0, "T8 op0");
    run_copy(32'h0001_0000, 32'h0008_0006, 32'h0003_0002, 32'h1234_0312, 32'hFFFF_FF3C, 0, 0, "T8 op3");
    run_copy(32'h0002_0000, 32'h0008_0006, 32'h0003_0002, 32'h0000_0600, 32'hFFFF_FF3C, 0, 0, "T8 op6");
    run_copy(32'h0003_0000, 32'h0008_0006, 32'h0003_0002, 32'h5A5A_0A5A, 32'hFFFF_FF3C, 0, 0, "T8 op10");
    run_copy(32'h0004_0000, 32'h0008_0006, 32'h0003_0002, 32'h0000_0F00, 32'hFFFF_FF3C, 0, 0, "T8 op15");
    // R7 unlisted code
    run_copy(32'h0005_0000, 32'h0008_0006, 32'h0003_0002, 32'h0000_0500, 32'h0000_00FF, 0, 0, "T8 op5 R7");
    // R9 control plane blocks start
    run_copy(32'h0000_0000, 32'h0004_0004, 32'h0003_0003, 32'h0000_0300, 32'h0000_00FF, 32'h1, 0, "T9");
    // R11 start while busy
    run_copy(32'h0006_0001, 32'h0001_0007, 32'h0003_0003, 32'h0000_0600, 32'h0000_00FF, 0, 1, "T10");
    // R11 empty rectangle
    run_copy(32'h0001_0001, 32'h0002_0002, 32'h0000_0005, 32'h0000_0300, 32'h0000_00FF, 0, 0, "T11");
    for (int i = 0; i < SZ; i++) begin
      if (mem[i] != model[i]) check(0, "R1 final memory", int'(mem[i]), int'(model[i]));
    end
    check(1, "R1 final memory scan", 0, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule